// File: doc/BRIEF.md
# Error Severity Classification and Message Reporter

This block sits beside a link receiver and turns per-type error pulses into error-message requests. Two groups of event inputs arrive: uncorrectable types, each with a "continuable" qualifier, and correctable types. Every event is latched into a status register whether or not it is masked.

For each unmasked event, a severity register and three reporting enables decide whether a fatal, non-fatal or correctable message request leaves the block. An uncorrectable non-fatal error that the receiver can keep running past is downgraded to a correctable (advisory) request. That downgrade exists only when the advanced-reporting parameter is set.

The first unmasked uncorrectable error captures the accompanying packet header and its type index. Software reads and clears all state through a simple word-addressed register port.

Top module: `errReporter`

## Requirements
- R1: A pulse on any bit of `uncEvt` or `corEvt` sets the matching status bit on the next clock edge. This happens regardless of mask, severity and enable settings. Status is read at word address 0 (uncorrectable) and word address 3 (correctable).
- R2: Writing a one to a status bit clears it, and writing a zero leaves it unchanged. When a clear and an event for the same bit land in the same cycle, the bit stays set.
- R3: An event whose mask bit is one produces no message request and does not touch the header log. The uncorrectable mask is at word address 1 and the correctable mask at word address 4.
- R4: An unmasked uncorrectable event whose severity bit is one raises a request with code 2'b11. The severity register is at word address 2. The request is raised only when fatal reporting (control bit 2) is enabled.
- R5: An unmasked uncorrectable event with severity zero and continuable flag zero raises code 2'b01. This happens only when non-fatal reporting (control bit 1) is enabled.
- R6: An unmasked uncorrectable event with severity zero and the continuable flag set raises code 2'b00 when correctable reporting (control bit 0) is enabled. With the parameter `ADV_EN` at 0, this case raises no request at all.
- R7: An unmasked correctable event raises code 2'b00 when control bit 0 is enabled. The control register is at word address 5.
- R8: At most one request (`msgValid` high for one cycle) is raised in the cycle after the events. It carries the highest enabled pending severity: fatal over non-fatal over correctable. Code 2'b10 never appears.
- R9: When no first error is held, any unmasked uncorrectable event captures `evtHdr` into the header log and records the lowest such index as the first-error pointer. The log reads at word addresses 8 to 11, least significant word first. The pointer reads at word address 6, with the index in bits [4:0] and a valid flag in bit 16. Log and pointer hold until software clears that pointer's status bit.
- R10: After reset every register reads zero and no request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| uncEvt | input | NUM_UNC | One-cycle uncorrectable error pulses, one per type |
| uncCont | input | NUM_UNC | Continuable qualifier for each uncorrectable pulse |
| corEvt | input | NUM_COR | One-cycle correctable error pulses, one per type |
| evtHdr | input | HDR_W | Header of the packet tied to the current events |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from `regAddr` |
| msgValid | output | 1 | One-cycle message request |
| msgCode | output | 2 | Message severity code: 00 correctable, 01 non-fatal, 11 fatal |

## Verification
A status bit that fails to latch, or a W1C that clears the wrong bit, shows up on the very next register read. A wrong enable or severity decode instead appears as a missing, extra or mis-coded request one cycle after the event. A first-error pointer that releases too early or never releases is exposed by the header-log words, either on the next capture or on the read that follows the clear. The scoreboard matches every request against the expected code in order, so a duplicate or a lost request is caught at the following event.

// File: rtl/errrep_pkg.sv
package errrep_pkg;

  typedef enum logic [1:0] {
    MSG_COR      = 2'b00,
    MSG_NONFATAL = 2'b01,
    MSG_FATAL    = 2'b11
  } msgCode_e;

  typedef struct packed {
    logic     msgFire;
    msgCode_e msgCode;
    logic     logCapture;
  } ctrlStrb_t;

  localparam logic [3:0] ADDR_UNC_STS  = 4'd0;
  localparam logic [3:0] ADDR_UNC_MASK = 4'd1;
  localparam logic [3:0] ADDR_UNC_SEV  = 4'd2;
  localparam logic [3:0] ADDR_COR_STS  = 4'd3;
  localparam logic [3:0] ADDR_COR_MASK = 4'd4;
  localparam logic [3:0] ADDR_CTRL     = 4'd5;
  localparam logic [3:0] ADDR_FIRST    = 4'd6;

  localparam int EN_COR   = 0;
  localparam int EN_NFAT  = 1;
  localparam int EN_FATAL = 2;

endpackage

// File: rtl/errCtrl.sv
module errCtrl
  import errrep_pkg::*;
#(
  parameter int NUM_UNC = 16,
  parameter int NUM_COR = 8,
  parameter int PTR_W   = 4,
  parameter bit ADV_EN  = 1'b1
) (
  input  logic [NUM_UNC-1:0] uncEvt,
  input  logic [NUM_UNC-1:0] uncCont,
  input  logic [NUM_COR-1:0] corEvt,
  input  logic [NUM_UNC-1:0] uncMask,
  input  logic [NUM_UNC-1:0] uncSev,
  input  logic [NUM_COR-1:0] corMask,
  input  logic [2:0]         repEn,
  input  logic               firstValid,
  output ctrlStrb_t          strb,
  output logic [PTR_W-1:0]   logPtr
);

  logic [NUM_UNC-1:0] uncHit;
  logic fatalHit, nfHit, advHit, corHit;

  always_comb begin
    uncHit   = uncEvt & ~uncMask;
    fatalHit = |(uncHit & uncSev);
    nfHit    = |(uncHit & ~uncSev & ~uncCont);
    advHit   = ADV_EN && (|(uncHit & ~uncSev & uncCont));
    corHit   = |(corEvt & ~corMask);

    strb = '0;
    if (fatalHit && repEn[EN_FATAL]) begin
      strb.msgFire = 1'b1;
      strb.msgCode = MSG_FATAL;
    end else if (nfHit && repEn[EN_NFAT]) begin
      strb.msgFire = 1'b1;
      strb.msgCode = MSG_NONFATAL;
    end else if ((corHit || advHit) && repEn[EN_COR]) begin
      strb.msgFire = 1'b1;
      strb.msgCode = MSG_COR;
    end
    strb.logCapture = !firstValid && (|uncHit);
  end

  // lowest unmasked index becomes the first-error pointer
  always_comb begin
    logPtr = '0;
    for (int i = NUM_UNC - 1; i >= 0; i--) begin
      if (uncHit[i]) logPtr = PTR_W'(i);
    end
  end

endmodule

// File: rtl/errDatapath.sv
module errDatapath
  import errrep_pkg::*;
#(
  parameter int NUM_UNC = 16,
  parameter int NUM_COR = 8,
  parameter int HDR_W   = 128,
  parameter int PTR_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_UNC-1:0] uncEvt,
  input  logic [NUM_COR-1:0] corEvt,
  input  logic [HDR_W-1:0]   evtHdr,
  input  logic               regWrEn,
  input  logic [3:0]         regAddr,
  input  logic [31:0]        regWrData,
  input  ctrlStrb_t          strb,
  input  logic [PTR_W-1:0]   logPtr,
  output logic [31:0]        regRdData,
  output logic [NUM_UNC-1:0] uncStatus,
  output logic [NUM_COR-1:0] corStatus,
  output logic [NUM_UNC-1:0] uncMask,
  output logic [NUM_UNC-1:0] uncSev,
  output logic [NUM_COR-1:0] corMask,
  output logic [2:0]         repEn,
  output logic               firstValid,
  output logic [HDR_W-1:0]   hdrLog,
  output logic               msgValid,
  output logic [1:0]         msgCode
);

  logic [PTR_W-1:0]   firstPtr;
  logic [NUM_UNC-1:0] uncClr, uncStatusNext;
  logic [NUM_COR-1:0] corClr;

  always_comb begin
    uncClr = (regWrEn && regAddr == ADDR_UNC_STS) ? regWrData[NUM_UNC-1:0] : '0;
    corClr = (regWrEn && regAddr == ADDR_COR_STS) ? regWrData[NUM_COR-1:0] : '0;
    uncStatusNext = (uncStatus & ~uncClr) | uncEvt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      uncStatus  <= '0;
      corStatus  <= '0;
      uncMask    <= '0;
      uncSev     <= '0;
      corMask    <= '0;
      repEn      <= '0;
      firstValid <= 1'b0;
      firstPtr   <= '0;
      hdrLog     <= '0;
      msgValid   <= 1'b0;
      msgCode    <= 2'b00;
    end else begin
      uncStatus <= uncStatusNext;
      corStatus <= (corStatus & ~corClr) | corEvt;
      if (regWrEn) begin
        case (regAddr)
          ADDR_UNC_MASK: uncMask <= regWrData[NUM_UNC-1:0];
          ADDR_UNC_SEV:  uncSev  <= regWrData[NUM_UNC-1:0];
          ADDR_COR_MASK: corMask <= regWrData[NUM_COR-1:0];
          ADDR_CTRL:     repEn   <= regWrData[2:0];
          default: ;
        endcase
      end
      if (strb.logCapture) begin
        firstValid <= 1'b1;
        firstPtr   <= logPtr;
        hdrLog     <= evtHdr;
      end else if (firstValid && !uncStatusNext[firstPtr]) begin
        firstValid <= 1'b0;
      end
      msgValid <= strb.msgFire;
      msgCode  <= strb.msgCode;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_UNC_STS:  regRdData[NUM_UNC-1:0] = uncStatus;
      ADDR_UNC_MASK: regRdData[NUM_UNC-1:0] = uncMask;
      ADDR_UNC_SEV:  regRdData[NUM_UNC-1:0] = uncSev;
      ADDR_COR_STS:  regRdData[NUM_COR-1:0] = corStatus;
      ADDR_COR_MASK: regRdData[NUM_COR-1:0] = corMask;
      ADDR_CTRL:     regRdData[2:0] = repEn;
      ADDR_FIRST: begin
        regRdData[PTR_W-1:0] = firstPtr;
        regRdData[16]        = firstValid;
      end
      default: if (regAddr[3]) regRdData = hdrLog[{regAddr[1:0], 5'b00000} +: 32];
    endcase
  end

endmodule

// File: rtl/errReporter.sv
module errReporter
  import errrep_pkg::*;
#(
  parameter int NUM_UNC = 16,
  parameter int NUM_COR = 8,
  parameter int HDR_W   = 128,
  parameter bit ADV_EN  = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_UNC-1:0] uncEvt,
  input  logic [NUM_UNC-1:0] uncCont,
  input  logic [NUM_COR-1:0] corEvt,
  input  logic [HDR_W-1:0]   evtHdr,
  input  logic               regWrEn,
  input  logic [3:0]         regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic               msgValid,
  output logic [1:0]         msgCode
);

  localparam int PTR_W = (NUM_UNC > 1) ? $clog2(NUM_UNC) : 1;

  ctrlStrb_t          strb;
  logic [PTR_W-1:0]   logPtr;
  logic [NUM_UNC-1:0] uncStatus, uncMask, uncSev;
  logic [NUM_COR-1:0] corStatus, corMask;
  logic [2:0]         repEn;
  logic               firstValid;
  logic [HDR_W-1:0]   hdrLog;

  errCtrl #(
    .NUM_UNC(NUM_UNC), .NUM_COR(NUM_COR), .PTR_W(PTR_W), .ADV_EN(ADV_EN)
  ) ctrl_i (
    .uncEvt(uncEvt), .uncCont(uncCont), .corEvt(corEvt),
    .uncMask(uncMask), .uncSev(uncSev), .corMask(corMask),
    .repEn(repEn), .firstValid(firstValid),
    .strb(strb), .logPtr(logPtr)
  );

  errDatapath #(
    .NUM_UNC(NUM_UNC), .NUM_COR(NUM_COR), .HDR_W(HDR_W), .PTR_W(PTR_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .uncEvt(uncEvt), .corEvt(corEvt), .evtHdr(evtHdr),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .strb(strb), .logPtr(logPtr), .regRdData(regRdData),
    .uncStatus(uncStatus), .corStatus(corStatus), .uncMask(uncMask),
    .uncSev(uncSev), .corMask(corMask), .repEn(repEn),
    .firstValid(firstValid), .hdrLog(hdrLog),
    .msgValid(msgValid), .msgCode(msgCode)
  );

endmodule

// File: rtl/errReporter_chk.sv
module errReporter_chk #(
  parameter int NUM_UNC = 16,
  parameter int NUM_COR = 8,
  parameter int HDR_W   = 128
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_UNC-1:0] uncEvt,
  input logic [NUM_COR-1:0] corEvt,
  input logic [NUM_UNC-1:0] uncStatus,
  input logic [NUM_UNC-1:0] uncMask,
  input logic [NUM_COR-1:0] corMask,
  input logic [2:0]         repEn,
  input logic               firstValid,
  input logic [HDR_W-1:0]   hdrLog,
  input logic               msgValid,
  input logic [1:0]         msgCode
);

  // R1
  status_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|uncEvt) |=> ((uncStatus & $past(uncEvt)) == $past(uncEvt)));

  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (((uncEvt & ~uncMask) == '0) && ((corEvt & ~corMask) == '0)) |=> !msgValid);

  // R4
  fatal_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !repEn[2] |=> !(msgValid && msgCode == 2'b11));

  // R8
  code_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgCode != 2'b10));

  // R9
  log_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    firstValid |=> (!firstValid || $stable(hdrLog)));

endmodule

bind errReporter errReporter_chk #(
  .NUM_UNC(NUM_UNC), .NUM_COR(NUM_COR), .HDR_W(HDR_W)
) chk_i (
  .clk(clk), .rstN(rstN), .uncEvt(uncEvt), .corEvt(corEvt),
  .uncStatus(uncStatus), .uncMask(uncMask), .corMask(corMask),
  .repEn(repEn), .firstValid(firstValid), .hdrLog(hdrLog),
  .msgValid(msgValid), .msgCode(msgCode)
);

// File: tb/errReporter_tb_top.sv
module errReporter_tb_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [15:0]  uncEvt = '0, uncCont = '0;
  logic [7:0]   corEvt = '0;
  logic [127:0] evtHdr = '0;
  logic         regWrEn = 1'b0;
  logic [3:0]   regAddr = '0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData, rdNoAdv;
  logic         msgValid, msgValid2;
  logic [1:0]   msgCode, msgCode2;

  int nChecks = 0;
  int nFails  = 0;
  logic [1:0] expQ[$];
  logic [15:0] mUnc = '0;
  logic [7:0]  mCor = '0;

  localparam logic [127:0] H1 = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
  localparam logic [127:0] H2 = 128'hdead_beef_0bad_f00d_1357_9bdf_2468_ace0;

  always #5 clk = ~clk;

  errReporter dut_i (
    .clk(clk), .rstN(rstN), .uncEvt(uncEvt), .uncCont(uncCont), .corEvt(corEvt),
    .evtHdr(evtHdr), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .msgValid(msgValid), .msgCode(msgCode)
  );

  errReporter #(.ADV_EN(1'b0)) dutNoAdv_i (
    .clk(clk), .rstN(rstN), .uncEvt(uncEvt), .uncCont(uncCont), .corEvt(corEvt),
    .evtHdr(evtHdr), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(rdNoAdv), .msgValid(msgValid2), .msgCode(msgCode2)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: every request must match the head of the scoreboard queue
  always @(negedge clk) begin
    if (rstN && msgValid) begin
      if (expQ.size() == 0) check(1'b0, "R8 unexpected request", {30'b0, msgCode}, 32'hffff_ffff);
      else begin
        logic [1:0] e;
        e = expQ.pop_front();
        check(msgCode == e, "R8 request code", {30'b0, msgCode}, {30'b0, e});
      end
    end
  end

  task automatic wrReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == 4'd0) mUnc &= ~d[15:0];
    if (a == 4'd3) mCor &= ~d[7:0];
  endtask

  task automatic rdCheck(input logic [3:0] a, input logic [31:0] e, input string req);
    regAddr = a;
    #1;
    check(regRdData == e, req, regRdData, e);
  endtask

  task automatic fire(input logic [15:0] u, input logic [15:0] c, input logic [7:0] r,
                      input logic [127:0] h, input bit expFire, input logic [1:0] code,
                      input string req);
    @(negedge clk);
    uncEvt = u; uncCont = c; corEvt = r; evtHdr = h;
    if (expFire) expQ.push_back(code);
    mUnc |= u; mCor |= r;
    @(negedge clk);
    uncEvt = '0; uncCont = '0; corEvt = '0;
    #1;
    if (!expFire) check(msgValid == 1'b0, req, {31'b0, msgValid}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    rdCheck(4'd0, 32'h0, "R10 unc status");
    rdCheck(4'd3, 32'h0, "R10 cor status");
    rdCheck(4'd5, 32'h0, "R10 control");
    rdCheck(4'd6, 32'h0, "R10 first pointer");
    check(msgValid == 1'b0, "R10 no request", {31'b0, msgValid}, 32'h0);

    wrReg(4'd5, 32'h7);
    wrReg(4'd2, 32'h4);
    wrReg(4'd1, 32'h20);

    // R5 non-fatal, R9 first capture
    fire(16'h1, 16'h0, 8'h0, H1, 1'b1, 2'b01, "R5");
    rdCheck(4'd0, {16'b0, mUnc}, "R1 unc status");
    rdCheck(4'd6, 32'h10000, "R9 pointer");
    rdCheck(4'd8, H1[31:0], "R9 log word0");
    rdCheck(4'd11, H1[127:96], "R9 log word3");
    // R4 fatal; log held
    fire(16'h4, 16'h0, 8'h0, H2, 1'b1, 2'b11, "R4");
    rdCheck(4'd8, H1[31:0], "R9 log held");
    // R8 priority: both together -> single fatal
    fire(16'h5, 16'h0, 8'h0, H2, 1'b1, 2'b11, "R8");
    // R6 advisory
    fire(16'h2, 16'h2, 8'h0, H2, 1'b1, 2'b00, "R6");
    check(msgValid2 == 1'b0, "R6 no advisory without ADV_EN", {31'b0, msgValid2}, 32'h0);
    // R7 correctable
    fire(16'h0, 16'h0, 8'h8, H2, 1'b1, 2'b00, "R7");
    rdCheck(4'd3, {24'b0, mCor}, "R1 cor status");
    // R3 masked, status still set
    fire(16'h20, 16'h0, 8'h0, H2, 1'b0, 2'b00, "R3 masked unc");
    rdCheck(4'd0, {16'b0, mUnc}, "R1 masked status");

    wrReg(4'd5, 32'h3);
    fire(16'h4, 16'h0, 8'h0, H2, 1'b0, 2'b00, "R4 fatal disabled");
    fire(16'h5, 16'h0, 8'h0, H2, 1'b1, 2'b01, "R8 fallback to non-fatal");

    wrReg(4'd5, 32'h6);
    fire(16'h0, 16'h0, 8'h1, H2, 1'b0, 2'b00, "R7 cor disabled");
    fire(16'h2, 16'h2, 8'h0, H2, 1'b0, 2'b00, "R6 cor disabled");
    rdCheck(4'd3, {24'b0, mCor}, "R1 cor status when disabled");

    wrReg(4'd4, 32'h2);
    wrReg(4'd5, 32'h7);
    fire(16'h0, 16'h0, 8'h2, H2, 1'b0, 2'b00, "R3 masked cor");
    rdCheck(4'd3, {24'b0, mCor}, "R1 masked cor status");

    // R2 clear bit0 releases pointer 0
    wrReg(4'd0, 32'h1);
    rdCheck(4'd0, {16'b0, mUnc}, "R2 W1C");
    rdCheck(4'd6, 32'h0, "R9 pointer released");
    fire(16'h10, 16'h0, 8'h0, H2, 1'b1, 2'b01, "R9 recapture");
    rdCheck(4'd6, 32'h10004, "R9 new pointer");
    rdCheck(4'd8, H2[31:0], "R9 new log");

    // R2 set wins over clear
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'd0; regWrData = 32'h10; uncEvt = 16'h10;
    expQ.push_back(2'b01);
    @(negedge clk);
    regWrEn = 1'b0; uncEvt = '0;
    rdCheck(4'd0, {16'b0, mUnc}, "R2 set wins");
    rdCheck(4'd6, 32'h10004, "R9 pointer kept");

    wrReg(4'd3, 32'hff);
    rdCheck(4'd3, 32'h0, "R2 cor W1C");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R8 missing request", expQ.size(), 32'h0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule